// File: doc/BRIEF.md
# In-Order Operand Streaming Sequencer

This block is the control core of a small application-specific processor. It walks a program held in a synchronous instruction memory, one instruction at a time and strictly in program order. Every instruction word names two source locations and one destination location in a synchronous data memory, together with an operation code. The sequencer reads the operand pairs, hands them to an external processing unit, and writes each returned result to the destination. The processing unit does the arithmetic and is reached only through a request strobe and a result-valid strobe.

One bit of the operation code chooses how much data a single instruction moves. In single mode, one operand pair is moved and one result is written. In block mode, a run of consecutive entries is streamed with one read per cycle, and the three addresses advance together. The sequencer waits for every result of the current instruction before it fetches the next one, so a later instruction always sees what an earlier one wrote. A reserved all-ones opcode parks the core with a done flag raised.

Top module: `blkseq_core`

## Requirements
- R1: While reset is high and in the first cycle after it falls, `done`, `pu_req`, `dmem_we` and `dmem_rd_en` are low, and the core fetches from instruction address 0 (`imem_rd_en` high, `imem_addr` = 0).
- R2: An instruction word is 3*AW+OP_W bits wide. Source A sits in the top AW bits, source B in the next AW bits, destination C in the AW bits below B, and the opcode in the lowest OP_W bits.
- R3: Instructions complete in program order. No instruction fetch happens while any result is still outstanding, so an instruction reads values written by the instructions before it.
- R4: With opcode MSB = 0, exactly one pair is read from addresses A and B, exactly one request is made, and exactly one result is written to C.
- R5: With opcode MSB = 1, BLK_LEN entries are moved. Entry i reads A+i and B+i and writes C+i, with every address wrapping modulo the data-memory size. `pu_last` is raised with the request of the final entry only.
- R6: The low OP_W-1 opcode bits appear unchanged on `pu_op` with every request.
- R7: Each request comes in the cycle right after its data-memory read. In block mode the reads, and therefore the requests, occur on BLK_LEN consecutive cycles.
- R8: For any fixed result latency, the core waits until every requested result has arrived, and it writes the results in arrival order.
- R9: An opcode of all ones halts the core. `done` then stays high until reset, and there is no further fetch, read, request or write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_rd_en | output | 1 | Instruction memory read strobe |
| imem_addr | output | PW | Program counter / instruction address |
| imem_rdata | input | IW | Instruction word, one cycle after the read strobe |
| dmem_rd_en | output | 1 | Data memory operand read strobe |
| dmem_ra_addr | output | AW | Operand A read address |
| dmem_rb_addr | output | AW | Operand B read address |
| dmem_ra_data | input | DATA_W | Operand A data, one cycle after the read |
| dmem_rb_data | input | DATA_W | Operand B data, one cycle after the read |
| dmem_we | output | 1 | Result write strobe |
| dmem_waddr | output | AW | Result write address |
| dmem_wdata | output | DATA_W | Result write data |
| pu_req | output | 1 | Operand pair valid toward processing unit |
| pu_op | output | OP_W-1 | Function code passed to processing unit |
| pu_opnd_a | output | DATA_W | Operand A |
| pu_opnd_b | output | DATA_W | Operand B |
| pu_last | output | 1 | Marks the final entry of the transfer |
| pu_res_valid | input | 1 | Result valid from processing unit |
| pu_res_data | input | DATA_W | Result value |
| done | output | 1 | Halted flag |

## Verification
The bench targets a block whose source range wraps past the top of data memory. A core that drops the modulo would read or write the wrong words, and the full memory compare would show it. It also runs a chained single instruction that reads a freshly written block result. A core that fetched early or read stale data would leave a wrong value. Slow result latencies exercise the stall: a core that advanced on a count of requests rather than results would write fewer entries. Words placed after a halt must never be executed, and a core that ignored the reserved code would overwrite a guarded location.

// File: rtl/blkseq_pkg.sv
package blkseq_pkg;

    typedef enum logic [2:0] {
        ST_FETCH    = 3'd0,
        ST_LOAD     = 3'd1,
        ST_DISPATCH = 3'd2,
        ST_RUN      = 3'd3,
        ST_HALT     = 3'd4
    } seq_state_t;

    typedef struct packed {
        logic halt;
        logic blk;
    } seq_mode_t;

    // Opcode layout: MSB picks the transfer mode, all ones is the stop code.
    function automatic seq_mode_t decode_mode(input logic [31:0] op, input int unsigned opw);
        seq_mode_t m;
        m.halt = (op == ((32'd1 << opw) - 32'd1));
        m.blk  = op[opw-1];
        return m;
    endfunction

endpackage

// File: rtl/blkseq_decode.sv
module blkseq_decode #(
    parameter int AW   = 6,
    parameter int OP_W = 4,
    localparam int IW  = 3*AW + OP_W
) (
    input  logic [IW-1:0]          instr,
    output logic [AW-1:0]          addr_a,
    output logic [AW-1:0]          addr_b,
    output logic [AW-1:0]          addr_c,
    output logic [OP_W-2:0]        fn,
    output blkseq_pkg::seq_mode_t  mode
);
    import blkseq_pkg::*;

    assign addr_a = instr[IW-1 -: AW];
    assign addr_b = instr[IW-AW-1 -: AW];
    assign addr_c = instr[OP_W+AW-1 -: AW];
    assign fn     = instr[OP_W-2:0];
    assign mode   = decode_mode(32'(instr[OP_W-1:0]), OP_W);
endmodule

// File: rtl/blkseq_counter.sv
module blkseq_counter #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/blkseq_fsm.sv
module blkseq_fsm (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     halt_code,
    input  logic                     issue_more,
    input  logic                     res_valid,
    input  logic                     last_ret,
    output blkseq_pkg::seq_state_t   state,
    output logic                     fetch_en,
    output logic                     load_ir,
    output logic                     clr_cnt,
    output logic                     issue_en,
    output logic                     retire_en,
    output logic                     pc_inc,
    output logic                     halted
);
    import blkseq_pkg::*;

    seq_state_t nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_FETCH:    nxt = ST_LOAD;
            ST_LOAD:     nxt = ST_DISPATCH;
            ST_DISPATCH: nxt = halt_code ? ST_HALT : ST_RUN;
            ST_RUN:      if (res_valid && last_ret) nxt = ST_FETCH;
            ST_HALT:     nxt = ST_HALT;
            default:     nxt = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_FETCH;
        end else begin
            state <= nxt;
        end
    end

    assign fetch_en  = (state == ST_FETCH);
    assign load_ir   = (state == ST_LOAD);
    assign clr_cnt   = (state == ST_DISPATCH);
    assign issue_en  = (state == ST_RUN) && issue_more;
    assign retire_en = (state == ST_RUN) && res_valid;
    assign pc_inc    = retire_en && last_ret;
    assign halted    = (state == ST_HALT);
endmodule

// File: rtl/blkseq_core.sv
module blkseq_core #(
    parameter int DATA_W  = 16,
    parameter int M_WORDS = 64,
    parameter int N_INSTR = 32,
    parameter int OP_W    = 4,
    parameter int BLK_LEN = 18,
    localparam int AW     = $clog2(M_WORDS),
    localparam int PW     = $clog2(N_INSTR),
    localparam int IW     = 3*AW + OP_W,
    localparam int CW     = $clog2(BLK_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst,
    output logic              imem_rd_en,
    output logic [PW-1:0]     imem_addr,
    input  logic [IW-1:0]     imem_rdata,
    output logic              dmem_rd_en,
    output logic [AW-1:0]     dmem_ra_addr,
    output logic [AW-1:0]     dmem_rb_addr,
    input  logic [DATA_W-1:0] dmem_ra_data,
    input  logic [DATA_W-1:0] dmem_rb_data,
    output logic              dmem_we,
    output logic [AW-1:0]     dmem_waddr,
    output logic [DATA_W-1:0] dmem_wdata,
    output logic              pu_req,
    output logic [OP_W-2:0]   pu_op,
    output logic [DATA_W-1:0] pu_opnd_a,
    output logic [DATA_W-1:0] pu_opnd_b,
    output logic              pu_last,
    input  logic              pu_res_valid,
    input  logic [DATA_W-1:0] pu_res_data,
    output logic              done
);
    import blkseq_pkg::*;

    logic [PW-1:0]   pc;
    logic [IW-1:0]   ir;
    logic [AW-1:0]   a_base, b_base, c_base;
    logic [OP_W-2:0] fn;
    seq_mode_t       mode;
    seq_state_t      state;
    logic [CW-1:0]   iss_cnt, ret_cnt, len;
    logic            fetch_en, load_ir, clr_cnt, issue_en, retire_en, pc_inc, halted;
    logic            issue_more, last_ret, last_iss;
    logic            rd_q, last_q;

    blkseq_decode #(.AW(AW), .OP_W(OP_W)) u_dec (
        .instr (ir),
        .addr_a(a_base),
        .addr_b(b_base),
        .addr_c(c_base),
        .fn    (fn),
        .mode  (mode)
    );

    assign len        = mode.blk ? CW'(BLK_LEN) : CW'(1);
    assign issue_more = (iss_cnt < len);
    assign last_iss   = (iss_cnt == len - CW'(1));
    assign last_ret   = (ret_cnt == len - CW'(1));

    blkseq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .halt_code (mode.halt),
        .issue_more(issue_more),
        .res_valid (pu_res_valid),
        .last_ret  (last_ret),
        .state     (state),
        .fetch_en  (fetch_en),
        .load_ir   (load_ir),
        .clr_cnt   (clr_cnt),
        .issue_en  (issue_en),
        .retire_en (retire_en),
        .pc_inc    (pc_inc),
        .halted    (halted)
    );

    blkseq_counter #(.CW(CW)) u_iss (
        .clk(clk), .rst(rst), .clr(clr_cnt), .inc(issue_en), .cnt(iss_cnt)
    );

    blkseq_counter #(.CW(CW)) u_ret (
        .clk(clk), .rst(rst), .clr(clr_cnt), .inc(retire_en), .cnt(ret_cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc     <= '0;
            ir     <= '0;
            rd_q   <= 1'b0;
            last_q <= 1'b0;
        end else begin
            if (load_ir) ir <= imem_rdata;
            if (pc_inc)  pc <= pc + PW'(1);
            rd_q   <= issue_en;
            last_q <= issue_en && last_iss;
        end
    end

    assign imem_rd_en   = fetch_en;
    assign imem_addr    = pc;
    assign dmem_rd_en   = issue_en;
    assign dmem_ra_addr = a_base + AW'(iss_cnt);
    assign dmem_rb_addr = b_base + AW'(iss_cnt);
    assign pu_req       = rd_q;
    assign pu_last      = last_q;
    assign pu_op        = fn;
    assign pu_opnd_a    = dmem_ra_data;
    assign pu_opnd_b    = dmem_rb_data;
    assign dmem_we      = retire_en;
    assign dmem_waddr   = c_base + AW'(ret_cnt);
    assign dmem_wdata   = pu_res_data;
    assign done         = halted;
endmodule

// File: rtl/blkseq_chk.sv
module blkseq_chk #(
    parameter int AW      = 6,
    parameter int BLK_LEN = 18
) (
    input logic          clk,
    input logic          rst,
    input logic          imem_rd_en,
    input logic          dmem_rd_en,
    input logic [AW-1:0] dmem_ra_addr,
    input logic [AW-1:0] dmem_rb_addr,
    input logic          dmem_we,
    input logic [AW-1:0] dmem_waddr,
    input logic          pu_req,
    input logic          pu_last,
    input logic          done
);
    localparam int OW = $clog2(BLK_LEN + 1) + 1;
    logic [OW-1:0] outstanding;

    always_ff @(posedge clk) begin
        if (rst) begin
            outstanding <= '0;
        end else if (pu_req && !dmem_we) begin
            outstanding <= outstanding + OW'(1);
        end else if (!pu_req && dmem_we) begin
            outstanding <= outstanding - OW'(1);
        end
    end

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        done |=> done); // R9
    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
        done |-> !(imem_rd_en || dmem_rd_en || pu_req || dmem_we)); // R9
    AST_REQ_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        dmem_rd_en |=> pu_req); // R7
    AST_REQ_NEEDS_READ: assert property (@(posedge clk) disable iff (rst)
        pu_req |-> $past(dmem_rd_en)); // R7
    AST_FETCH_DRAINED: assert property (@(posedge clk) disable iff (rst)
        imem_rd_en |-> (outstanding == '0)); // R3
    AST_WADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (dmem_we && $past(dmem_we)) |-> (dmem_waddr == AW'($past(dmem_waddr) + 1'b1))); // R5
    AST_RADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (dmem_rd_en && $past(dmem_rd_en)) |->
        ((dmem_ra_addr == AW'($past(dmem_ra_addr) + 1'b1)) &&
         (dmem_rb_addr == AW'($past(dmem_rb_addr) + 1'b1)))); // R5
    AST_LAST_WITH_REQ: assert property (@(posedge clk) disable iff (rst)
        pu_last |-> pu_req); // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        outstanding <= OW'(BLK_LEN)); // R8
endmodule

bind blkseq_core blkseq_chk #(.AW(AW), .BLK_LEN(BLK_LEN)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .imem_rd_en  (imem_rd_en),
    .dmem_rd_en  (dmem_rd_en),
    .dmem_ra_addr(dmem_ra_addr),
    .dmem_rb_addr(dmem_rb_addr),
    .dmem_we     (dmem_we),
    .dmem_waddr  (dmem_waddr),
    .pu_req      (pu_req),
    .pu_last     (pu_last),
    .done        (done)
);

// File: tb/blkseq_core_test.sv
`timescale 1ns/1ps
module blkseq_core_test;
    localparam int DW = 16, M = 64, N = 32, BL = 18, OPW = 4;
    localparam int AW = 6, PW = 5, IW = 22;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic          imem_rd_en, dmem_rd_en, dmem_we, pu_req, pu_last, done;
    logic [PW-1:0] imem_addr;
    logic [IW-1:0] imem_rdata;
    logic [AW-1:0] ra, rb, waddr;
    logic [DW-1:0] ra_data, rb_data, wdata, opa, opb;
    logic [OPW-2:0] pu_op;
    logic          res_valid;
    logic [DW-1:0] res_data;

    blkseq_core uut (
        .clk(clk), .rst(rst),
        .imem_rd_en(imem_rd_en), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_rd_en(dmem_rd_en), .dmem_ra_addr(ra), .dmem_rb_addr(rb),
        .dmem_ra_data(ra_data), .dmem_rb_data(rb_data),
        .dmem_we(dmem_we), .dmem_waddr(waddr), .dmem_wdata(wdata),
        .pu_req(pu_req), .pu_op(pu_op), .pu_opnd_a(opa), .pu_opnd_b(opb),
        .pu_last(pu_last), .pu_res_valid(res_valid), .pu_res_data(res_data),
        .done(done)
    );

    // Memories owned by the bench
    logic [IW-1:0] imem [N];
    logic [DW-1:0] dmem [M];
    logic [DW-1:0] expm [M];
    logic          ld_we = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [DW-1:0] ld_data = '0;

    always @(posedge clk) if (imem_rd_en) imem_rdata <= imem[imem_addr];

    always @(posedge clk) begin
        if (dmem_rd_en) begin
            ra_data <= dmem[ra];
            rb_data <= dmem[rb];
        end
        if (ld_we) dmem[ld_addr] <= ld_data;
        else if (dmem_we) dmem[waddr] <= wdata;
    end

    // Processing unit model: fixed latency, result = a + b + code
    int pu_lat = 1;
    logic          pv [8];
    logic [DW-1:0] pd [8];
    always @(posedge clk) begin
        for (int i = 0; i < 7; i++) begin
            pv[i] <= pv[i+1];
            pd[i] <= pd[i+1];
        end
        pv[7] <= 1'b0;
        if (rst) begin
            for (int i = 0; i < 8; i++) pv[i] <= 1'b0;
        end else if (pu_req) begin
            pv[pu_lat-1] <= 1'b1;
            pd[pu_lat-1] <= opa + opb + DW'(pu_op);
        end
    end
    assign res_valid = pv[0];
    assign res_data  = pd[0];

    // Port monitors
    int req_cnt, we_cnt, run_cur, run_max, viol, fetch_done, last_cnt;
    logic prev_rd;
    always @(posedge clk) begin
        if (rst) begin
            req_cnt <= 0; we_cnt <= 0; run_cur <= 0; run_max <= 0;
            viol <= 0; fetch_done <= 0; last_cnt <= 0; prev_rd <= 1'b0;
        end else begin
            prev_rd <= dmem_rd_en;
            if (pu_req) req_cnt <= req_cnt + 1;
            if (pu_last) last_cnt <= last_cnt + 1;
            if (dmem_we) we_cnt <= we_cnt + 1;
            if (pu_req && !prev_rd) viol <= viol + 1;
            if (done && (imem_rd_en || dmem_rd_en || dmem_we)) fetch_done <= fetch_done + 1;
            if (dmem_rd_en) begin
                run_cur <= run_cur + 1;
                if (run_cur + 1 > run_max) run_max <= run_cur + 1;
            end else begin
                run_cur <= 0;
            end
        end
    end

    int checks = 0, errors = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic logic [IW-1:0] mk(input int a, input int b, input int c,
                                         input logic [3:0] op);
        return {AW'(a), AW'(b), AW'(c), op};
    endfunction

    task automatic prep(input int seed, input int lat);
        rst = 1'b1;
        pu_lat = lat;
        for (int i = 0; i < N; i++) imem[i] = mk(0, 0, 0, 4'hF);
        for (int i = 0; i < M; i++) begin
            @(negedge clk);
            ld_we = 1'b1;
            ld_addr = AW'(i);
            ld_data = DW'(i * seed + 3);
            expm[i] = DW'(i * seed + 3);
        end
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic model();
        for (int p = 0; p < N; p++) begin
            logic [3:0] op;
            logic [AW-1:0] a, b, c;
            int len;
            op = imem[p][3:0];
            if (op == 4'hF) break;
            {a, b, c} = imem[p][IW-1:OPW];
            len = op[3] ? BL : 1;
            for (int i = 0; i < len; i++)
                expm[AW'(c + AW'(i))] = expm[AW'(a + AW'(i))] + expm[AW'(b + AW'(i))] + DW'(op[2:0]);
        end
    endtask

    task automatic start_and_wait(input string req);
        int cyc;
        model();
        repeat (2) @(negedge clk);
        rst = 1'b0;
        cyc = 0;
        while (!done && cyc < 3000) begin
            @(negedge clk);
            cyc++;
        end
        chk(done === 1'b1, req, "done reached", int'(done), 1);
    endtask

    task automatic mem_check(input string req);
        int bad, first;
        bad = 0; first = -1;
        for (int i = 0; i < M; i++) if (dmem[i] !== expm[i]) begin
            bad++;
            if (first < 0) first = i;
        end
        if (bad == 0) chk(1'b1, req, "memory", 0, 0);
        else chk(1'b0, req, $sformatf("memory word %0d", first), int'(dmem[first]), int'(expm[first]));
    endtask

    task automatic t_reset();
        prep(7, 1);
        chk(done === 1'b0 && pu_req === 1'b0 && dmem_we === 1'b0, "R1", "idle in reset", int'(done), 0);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(imem_rd_en === 1'b1, "R1", "first fetch strobe", int'(imem_rd_en), 1);
        chk(imem_addr === '0, "R1", "first fetch address", int'(imem_addr), 0);
        chk(dmem_rd_en === 1'b0 && dmem_we === 1'b0, "R1", "no data access", int'(dmem_rd_en), 0);
        chk(done === 1'b0, "R1", "done low", int'(done), 0);
    endtask

    task automatic t_single();
        prep(5, 1);
        imem[0] = mk(1, 2, 10, 4'h0);
        imem[1] = mk(3, 4, 11, 4'h5);
        imem[2] = mk(10, 11, 12, 4'h3);
        start_and_wait("R4");
        mem_check("R2 R3 R4 R6");
        chk(req_cnt == 3, "R4", "requests", req_cnt, 3);
        chk(we_cnt == 3, "R4", "writes", we_cnt, 3);
    endtask

    task automatic t_block();
        prep(11, 1);
        imem[0] = mk(0, 20, 40, 4'hA);
        start_and_wait("R5");
        mem_check("R5 R6");
        chk(req_cnt == BL, "R5", "block requests", req_cnt, BL);
        chk(last_cnt == 1, "R5", "last flags", last_cnt, 1);
        chk(run_max == BL, "R7", "consecutive reads", run_max, BL);
        chk(viol == 0, "R7", "request without prior read", viol, 0);
    endtask

    task automatic t_wrap_chain();
        prep(13, 5);
        imem[0] = mk(50, 4, 22, 4'hC);
        imem[1] = mk(22, 39, 60, 4'h1);
        start_and_wait("R5");
        mem_check("R3 R5 R8");
        chk(req_cnt == BL + 1, "R8", "requests", req_cnt, BL + 1);
    endtask

    task automatic t_slow();
        prep(3, 7);
        imem[0] = mk(0, 18, 40, 4'hE);
        start_and_wait("R8");
        mem_check("R8");
        chk(we_cnt == BL, "R8", "writes with slow unit", we_cnt, BL);
    endtask

    task automatic t_halt();
        prep(9, 2);
        imem[0] = mk(5, 6, 7, 4'h2);
        imem[2] = mk(1, 1, 60, 4'h0);
        start_and_wait("R9");
        repeat (20) @(negedge clk);
        chk(done === 1'b1, "R9", "done held", int'(done), 1);
        chk(fetch_done == 0, "R9", "activity after halt", fetch_done, 0);
        chk(we_cnt == 1, "R9", "writes", we_cnt, 1);
        mem_check("R9");
    endtask

    initial begin
        t_reset();
        t_single();
        t_block();
        t_wrap_chain();
        t_slow();
        t_halt();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule